// File: doc/BRIEF.md
# Immediate-Amount Operand Shifter

This block forms the second ALU operand of a processor datapath from a register value, and produces the shifter carry that the flag logic may later take. It takes a 32-bit source word, a 2-bit shift kind, a 5-bit immediate amount and the current carry flag. It returns the shifted word and a carry-out bit. Four kinds are supported: logical left, logical right, arithmetic right and rotate right.

An amount field of zero is not a plain no-op for the right-going kinds. For the two right shifts it stands for a shift by the full word width. For rotate it selects a one-bit rotate through the carry flag. The datapath is combinational and ends in one output register, so a result appears one clock after its inputs. Reset is synchronous and active high.

Top module: `opnd_shifter`

## Requirements
- R1: While `rst` is high at a rising edge, `res` and `cout` are 0 after that edge.
- R2: Outputs are registered. The values on `res` and `cout` after a rising edge are computed from the inputs sampled at that edge.
- R3: Kind 2'b00 (logical left) with amount 0 gives `res` equal to `src` and `cout` equal to `cin`.
- R4: Kind 2'b00 with amount n from 1 to 31 gives `src` shifted left by n with zero fill and `cout` equal to `src[32-n]`.
- R5: Kind 2'b01 (logical right) with amount n from 1 to 31 gives `src` shifted right by n with zero fill and `cout` equal to `src[n-1]`.
- R6: Kind 2'b01 with amount 0 acts as a shift by 32. `res` is 0 and `cout` equals `src[31]`.
- R7: Kind 2'b10 (arithmetic right) with amount n from 1 to 31 fills the vacated high bits with `src[31]` and gives `cout` equal to `src[n-1]`.
- R8: Kind 2'b10 with amount 0 acts as a shift by 32. Every bit of `res` and `cout` equal `src[31]`.
- R9: Kind 2'b11 (rotate right) with amount n from 1 to 31 moves the low n bits of `src` to the top, and `cout` equals `res[31]`.
- R10: Kind 2'b11 with amount 0 rotates right by one through carry. `res` is `{cin, src[31:1]}` and `cout` is `src[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src | input | 32 | Register value to shift |
| kind | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| amt | input | 5 | Immediate shift amount; 0 has the special meanings given in R3, R6, R8 and R10 |
| cin | input | 1 | Current carry flag |
| res | output | 32 | Shifted operand, registered |
| cout | output | 1 | Shifter carry-out, registered |

## Verification
The block holds no state other than its output register, so any wrong internal decision shows up on `res` or `cout` one clock after the offending inputs. The cases most likely to hide an error are the zero-amount encodings. If the amount is decoded wrongly, a right shift by 32 appears as a pass-through. A wrong carry-index calculation shifts the reported carry by one bit position. A rotate-through-carry that drops `cin` corrupts only bit 31. The bench sweeps every kind against every amount, using several data patterns and both carry values, so each of these faults appears at the first affected vector.

// File: rtl/opnd_shifter_pkg.sv
package opnd_shifter_pkg;
  typedef enum logic [1:0] {
    SHK_LSL = 2'b00,
    SHK_LSR = 2'b01,
    SHK_ASR = 2'b10,
    SHK_ROR = 2'b11
  } shk_e;
endpackage

// File: rtl/opnd_shift_decode.sv
module opnd_shift_decode
  import opnd_shifter_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W)
) (
  input  logic [1:0]       kind,
  input  logic [AMT_W-1:0] amt,
  input  logic             msb,
  output logic [AMT_W:0]   eff,
  output logic             go_left,
  output logic             rot,
  output logic             fill,
  output logic             rrx
);
  shk_e k;
  logic zero_amt;

  always_comb begin
    k        = shk_e'(kind);
    zero_amt = (amt == '0);
    go_left  = (k == SHK_LSL);
    rot      = (k == SHK_ROR);
    fill     = (k == SHK_ASR) ? msb : 1'b0;
    rrx      = rot && zero_amt;
    if (zero_amt) begin
      unique case (k)
        SHK_LSR, SHK_ASR: eff = (AMT_W+1)'(W);
        SHK_ROR:          eff = (AMT_W+1)'(1);
        default:          eff = '0;
      endcase
    end else begin
      eff = {1'b0, amt};
    end
  end
endmodule

// File: rtl/opnd_shift_core.sv
module opnd_shift_core #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [AMT_W:0] eff,
  input  logic           go_left,
  input  logic           rot,
  input  logic           fill,
  output logic [W-1:0]   dout
);
  localparam int STAGES = AMT_W + 1;

  logic [W-1:0] stage [STAGES+1];
  logic [W-1:0] flipped_in;
  logic [W-1:0] flipped_out;

  for (genvar b = 0; b < W; b++) begin : g_rev
    assign flipped_in[b]  = din[W-1-b];
    assign flipped_out[b] = stage[STAGES][W-1-b];
  end

  assign stage[0] = go_left ? flipped_in : din;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int SH = 1 << k;
    if (SH < W) begin : g_part
      always_comb begin
        if (!eff[k])  stage[k+1] = stage[k];
        else if (rot) stage[k+1] = {stage[k][SH-1:0], stage[k][W-1:SH]};
        else          stage[k+1] = {{SH{fill}}, stage[k][W-1:SH]};
      end
    end else begin : g_full
      always_comb begin
        if (!eff[k]) stage[k+1] = stage[k];
        else         stage[k+1] = {W{fill}};
      end
    end
  end

  assign dout = go_left ? flipped_out : stage[STAGES];
endmodule

// File: rtl/opnd_shift_carry.sv
module opnd_shift_carry #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [AMT_W:0] eff,
  input  logic           go_left,
  input  logic           rot,
  input  logic           rrx,
  input  logic           cin,
  input  logic           top_bit,
  output logic           cout
);
  logic [AMT_W-1:0] idx;

  always_comb begin
    if (go_left) idx = AMT_W'(W - int'(eff));
    else         idx = AMT_W'(int'(eff) - 1);
    if (rrx)                 cout = din[0];
    else if (eff == '0)      cout = cin;
    else if (rot)            cout = top_bit;
    else                     cout = din[idx];
  end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     src,
  input  logic [1:0]       kind,
  input  logic [AMT_W-1:0] amt,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cout
);
  logic [AMT_W:0] eff;
  logic           go_left, rot, fill, rrx;
  logic [W-1:0]   shifted, nxt_res;
  logic           nxt_cout;

  opnd_shift_decode #(.W(W), .AMT_W(AMT_W)) u_dec (
    .kind(kind), .amt(amt), .msb(src[W-1]), .eff(eff),
    .go_left(go_left), .rot(rot), .fill(fill), .rrx(rrx)
  );

  opnd_shift_core #(.W(W), .AMT_W(AMT_W)) u_core (
    .din(src), .eff(eff), .go_left(go_left), .rot(rot), .fill(fill),
    .dout(shifted)
  );

  assign nxt_res = rrx ? {cin, shifted[W-2:0]} : shifted;

  opnd_shift_carry #(.W(W), .AMT_W(AMT_W)) u_carry (
    .din(src), .eff(eff), .go_left(go_left), .rot(rot), .rrx(rrx),
    .cin(cin), .top_bit(shifted[W-1]), .cout(nxt_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res  <= '0;
      cout <= 1'b0;
    end else begin
      res  <= nxt_res;
      cout <= nxt_cout;
    end
  end
endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk #(
  parameter int W     = 32,
  parameter int AMT_W = $clog2(W)
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     src,
  input logic [1:0]       kind,
  input logic [AMT_W-1:0] amt,
  input logic             cin,
  input logic [W-1:0]     res,
  input logic             cout
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (res == '0 && !cout)); // R1

  AST_LSL0_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(kind) == 2'b00 && $past(amt) == '0)
      |-> (res == $past(src) && cout == $past(cin))); // R3

  AST_LSR32_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(kind) == 2'b01 && $past(amt) == '0)
      |-> (res == '0 && cout == $past(src[W-1]))); // R6

  AST_ASR32_SIGN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(kind) == 2'b10 && $past(amt) == '0)
      |-> (res == {W{$past(src[W-1])}} && cout == $past(src[W-1]))); // R8

  AST_ROR_CARRY_TOP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(kind) == 2'b11 && $past(amt) != '0)
      |-> (cout == res[W-1])); // R9

  AST_RRX_CARRY_IN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(kind) == 2'b11 && $past(amt) == '0)
      |-> (res[W-1] == $past(cin) && cout == $past(src[0]))); // R10
endmodule

bind opnd_shifter opnd_shifter_chk #(.W(W), .AMT_W(AMT_W)) u_chk (
  .clk(clk), .rst(rst), .src(src), .kind(kind), .amt(amt), .cin(cin),
  .res(res), .cout(cout)
);

// File: tb/opnd_shifter_test.sv
module opnd_shifter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = 32'hFFFF_FFFF;
  logic [1:0]  kind = 2'b00;
  logic [4:0]  amt = 5'd3;
  logic        cin = 1'b1;
  logic [31:0] res;
  logic        cout;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [32:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  opnd_shifter uut (
    .clk(clk), .rst(rst), .src(src), .kind(kind), .amt(amt), .cin(cin),
    .res(res), .cout(cout)
  );

  function automatic logic [32:0] model(logic [1:0] k, logic [31:0] s,
                                        logic [4:0] a, logic c);
    logic [32:0] t;
    logic [31:0] r;
    int n;
    n = (a == 0) ? 32 : int'(a);
    case (k)
      2'b00: begin
        if (a == 0) return {c, s};
        t = {1'b0, s} << a;
        return {t[32], t[31:0]};
      end
      2'b01: begin
        t = {s, 1'b0} >> n;
        return {t[0], t[32:1]};
      end
      2'b10: begin
        t = 33'($signed({s, 1'b0}) >>> n);
        return {t[0], t[32:1]};
      end
      default: begin
        if (a == 0) return {s[0], c, s[31:1]};
        r = (s >> a) | (s << (32 - n));
        return {r[31], r};
      end
    endcase
  endfunction

  function automatic string req_tag(logic [1:0] k, logic [4:0] a);
    case (k)
      2'b00:   return (a == 0) ? "R3" : "R4";
      2'b01:   return (a == 0) ? "R6" : "R5";
      2'b10:   return (a == 0) ? "R8" : "R7";
      default: return (a == 0) ? "R10" : "R9";
    endcase
  endfunction

  task automatic check_front();
    logic [32:0] e;
    string t;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    total++;
    if ({cout, res} !== e) begin
      bad++;
      $display("FAIL %s: got res=%h cout=%b expected res=%h cout=%b",
               t, res, cout, e[31:0], e[32]);
    end
  endtask

  task automatic drive(logic [1:0] k, logic [4:0] a, logic [31:0] s, logic c,
                       string t);
    @(negedge clk);
    check_front();
    kind = k; amt = a; src = s; cin = c;
    exp_q.push_back(model(k, s, a, c));
    tag_q.push_back(t);
  endtask

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hA5C3_0F96;
    pats[3] = 32'h1234_5678;
    pats[4] = 32'hFFFF_FFFF;
    pats[5] = 32'h0000_0000;

    repeat (3) @(negedge clk);
    total++;
    if (res !== 32'h0 || cout !== 1'b0) begin
      bad++;
      $display("FAIL R1: got res=%h cout=%b expected res=0 cout=0", res, cout);
    end
    @(negedge clk);
    rst = 1'b0;

    // R2: the first post-reset vector is compared exactly one edge later
    drive(2'b01, 5'd4, 32'hF000_0008, 1'b0, "R2");

    for (int p = 0; p < 6; p++)
      for (int ci = 0; ci < 2; ci++)
        for (int k = 0; k < 4; k++)
          for (int a = 0; a < 32; a++)
            drive(2'(k), 5'(a), pats[p], 1'(ci), req_tag(2'(k), 5'(a)));

    // R1: a reset in the middle of the stream clears the outputs
    @(negedge clk);
    check_front();
    rst = 1'b1; kind = 2'b11; amt = 5'd0; src = 32'hFFFF_FFFF; cin = 1'b1;
    @(negedge clk);
    total++;
    if (res !== 32'h0 || cout !== 1'b0) begin
      bad++;
      $display("FAIL R1: got res=%h cout=%b expected res=0 cout=0", res, cout);
    end
    rst = 1'b0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule